// File: doc/BRIEF.md
# Extended-Dividend Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor over many clock cycles and returns a 32-bit quotient for a 32-bit processor core. The dividend's upper half comes from a high-word register and its lower half from the first source operand. The divisor is the second source operand. A mode input chooses unsigned or two's-complement signed division for each operation.

The full quotient can be wider than 32 bits. When that happens, the block saturates the result and raises an overflow flag. A zero divisor produces a one-cycle trap pulse instead of a result. The core issues an operation with a one-cycle start pulse. It waits while busy is high and collects the result when done strobes.

Inside, the block runs radix-2 restoring division on operand magnitudes. It produces all 64 quotient bits, one per cycle. Overflow is then judged exactly from that full-width quotient, and the sign is applied last.

Top module: `xdiv_unit`

## Requirements
- R1: On a start pulse while idle, the dividend is taken as `{hi_word_i, op_a_i}`, with the high word in bits 63:32, and the divisor is `op_b_i`.
- R2: In unsigned mode (`signed_i`=0), a quotient that fits in 32 bits is returned exactly. A quotient above 0xFFFFFFFF returns 0xFFFFFFFF with `ovf_o` set.
- R3: A zero divisor pulses `dz_trap_o` for exactly one cycle, in the cycle after start. No done strobe follows, busy stays low, and `quot_o`/`ovf_o` keep their previous values.
- R4: In signed mode (`signed_i`=1), the quotient is truncated toward zero. A value in the range -2^31..2^31-1 is returned exactly with `ovf_o` clear.
- R5: In signed mode, a positive quotient above 0x7FFFFFFF returns 0x7FFFFFFF with `ovf_o` set. A negative quotient below -2^31 returns 0x80000000 with `ovf_o` set.
- R6: In signed mode, a dividend of 0x8000000000000000 always overflows. It gives 0x7FFFFFFF for a negative divisor and 0x80000000 for a positive divisor.
- R7: `busy_o` rises in the cycle after an accepted start. `done_o` is high for exactly one cycle, 64 cycles after the start edge, and `busy_o` is low in that cycle.
- R8: A start pulse while `busy_o` is high is ignored. The running operation's result and timing are unchanged.
- R9: After reset, `busy_o`, `done_o`, `dz_trap_o` and `ovf_o` are 0 and `quot_o` is 0.
- R10: `quot_o` and `ovf_o` change only together with a `done_o` strobe and hold between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a division |
| signed_i | input | 1 | 1 = signed, 0 = unsigned |
| hi_word_i | input | 32 | Dividend bits 63:32 |
| op_a_i | input | 32 | Dividend bits 31:0 |
| op_b_i | input | 32 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | 32 | Quotient, saturated on overflow |
| ovf_o | output | 1 | Quotient did not fit in 32 bits |
| dz_trap_o | output | 1 | One-cycle divide-by-zero trap |

## Verification
The assertions assume that `start_i` and the operands are stable around the clock edge, and that reset is applied before any request. They do not assume that start is withheld during busy. The bench drives every input on the falling edge, so each value is settled at the sampling edge. It also deliberately pulses start mid-run with different operands, to confirm the unit ignores it. Random operands are shaped so that in-range, overflowing, negative and zero-divisor cases all appear, with directed cases added for the most-negative dividend and the saturation boundaries.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
    localparam int unsigned XDIV_W = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xdiv_state_e;
endpackage

// File: rtl/xdiv_magnitude.sv
module xdiv_magnitude #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = signed_i & val_i[W-1];
        mag_o = neg_o ? (~val_i + {{(W-1){1'b0}}, 1'b1}) : val_i;
    end
endmodule

// File: rtl/xdiv_step.sv
module xdiv_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   rem_i,
    input  logic [2*W-1:0] sh_i,
    input  logic [W-1:0]   div_i,
    output logic [W-1:0]   rem_o,
    output logic [2*W-1:0] sh_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       take;

    always_comb begin
        trial = {rem_i, sh_i[2*W-1]};
        diff  = trial - {1'b0, div_i};
        take  = (trial >= {1'b0, div_i});
        rem_o = take ? diff[W-1:0] : trial[W-1:0];
        sh_o  = {sh_i[2*W-2:0], take};
    end
endmodule

// File: rtl/xdiv_finish.sv
module xdiv_finish #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] qmag_i,
    input  logic           neg_i,
    input  logic           signed_i,
    output logic [W-1:0]   quot_o,
    output logic           ovf_o
);
    localparam logic [2*W-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [2*W-1:0] NEG_LIM = {{(W){1'b0}}, 1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]   S_MAX   = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]   S_MIN   = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] low;

    always_comb begin
        low = qmag_i[W-1:0];
        if (!signed_i) begin
            ovf_o  = |qmag_i[2*W-1:W];
            quot_o = ovf_o ? {W{1'b1}} : low;
        end else if (neg_i) begin
            ovf_o  = qmag_i > NEG_LIM;
            quot_o = ovf_o ? S_MIN : (~low + {{(W-1){1'b0}}, 1'b1});
        end else begin
            ovf_o  = qmag_i > POS_LIM;
            quot_o = ovf_o ? S_MAX : low;
        end
    end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
    import xdiv_pkg::*;
#(
    parameter int unsigned W = XDIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] hi_word_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic         ovf_o,
    output logic         dz_trap_o
);
    localparam int unsigned ITER = 2 * W;
    localparam int unsigned CW   = $clog2(ITER);
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    typedef struct packed {
        xdiv_state_e    st;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   rem;
        logic [2*W-1:0] sh;
        logic [W-1:0]   dvs;
        logic           neg;
        logic           mode;
        logic [W-1:0]   quot;
        logic           ovf;
        logic           done;
        logic           trap;
    } xdiv_regs_t;

    xdiv_regs_t r_d, r_q;

    logic [2*W-1:0] dvd_mag;
    logic [W-1:0]   dvs_mag;
    logic           dvd_neg, dvs_neg;
    logic [W-1:0]   step_rem;
    logic [2*W-1:0] step_sh;
    logic [W-1:0]   fin_quot;
    logic           fin_ovf;

    xdiv_magnitude #(.W(2*W)) i_dvd_mag (
        .val_i    ({hi_word_i, op_a_i}),
        .signed_i (signed_i),
        .mag_o    (dvd_mag),
        .neg_o    (dvd_neg)
    );

    xdiv_magnitude #(.W(W)) i_dvs_mag (
        .val_i    (op_b_i),
        .signed_i (signed_i),
        .mag_o    (dvs_mag),
        .neg_o    (dvs_neg)
    );

    xdiv_step #(.W(W)) i_step (
        .rem_i (r_q.rem),
        .sh_i  (r_q.sh),
        .div_i (r_q.dvs),
        .rem_o (step_rem),
        .sh_o  (step_sh)
    );

    xdiv_finish #(.W(W)) i_finish (
        .qmag_i   (step_sh),
        .neg_i    (r_q.neg),
        .signed_i (r_q.mode),
        .quot_o   (fin_quot),
        .ovf_o    (fin_ovf)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.trap = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_b_i == '0) begin
                        r_d.trap = 1'b1;
                    end else begin
                        r_d.st   = ST_RUN;
                        r_d.cnt  = '0;
                        r_d.rem  = '0;
                        r_d.sh   = dvd_mag;
                        r_d.dvs  = dvs_mag;
                        r_d.neg  = dvd_neg ^ dvs_neg;
                        r_d.mode = signed_i;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem = step_rem;
                r_d.sh  = step_sh;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.quot = fin_quot;
                    r_d.ovf  = fin_ovf;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st == ST_RUN);
    assign done_o    = r_q.done;
    assign quot_o    = r_q.quot;
    assign ovf_o     = r_q.ovf;
    assign dz_trap_o = r_q.trap;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap_o |=> !dz_trap_o); // R3
    AST_TRAP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap_o |-> (!done_o && !busy_o && $stable(quot_o) && $stable(ovf_o))); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quot_o) && $stable(ovf_o))); // R10
    AST_UNSIGNED_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o && !r_q.mode) |-> (quot_o == {W{1'b1}})); // R2
    AST_SIGNED_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o && r_q.mode) |->
        (quot_o == {1'b0, {(W-1){1'b1}}} || quot_o == {1'b1, {(W-1){1'b0}}})); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && r_q.cnt != LAST) |=> busy_o); // R8
endmodule

// File: tb/test_xdiv_unit.sv
module test_xdiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] hi_word_i = '0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        busy_o, done_o, ovf_o, dz_trap_o;
    logic [31:0] quot_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xdiv_unit i_xdiv_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .hi_word_i(hi_word_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .ovf_o(ovf_o), .dz_trap_o(dz_trap_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] hi, input logic [31:0] a,
                                  input logic [31:0] b, input bit sgn,
                                  output logic [31:0] q, output bit ov);
        logic [63:0] un, uq;
        longint sn, sd, sq;
        if (!sgn) begin
            un = {hi, a};
            uq = un / {32'd0, b};
            ov = (uq > 64'h0000_0000_FFFF_FFFF);
            q  = ov ? 32'hFFFF_FFFF : uq[31:0];
        end else begin
            sn = {hi, a};
            sd = $signed(b);
            if ({hi, a} == 64'h8000_0000_0000_0000) begin
                ov = 1'b1;
                q  = b[31] ? 32'h7FFF_FFFF : 32'h8000_0000;
            end else begin
                sq = sn / sd;
                if (sq > 64'sd2147483647) begin
                    ov = 1'b1; q = 32'h7FFF_FFFF;
                end else if (sq < -64'sd2147483648) begin
                    ov = 1'b1; q = 32'h8000_0000;
                end else begin
                    ov = 1'b0; q = sq[31:0];
                end
            end
        end
    endfunction

    task automatic run_op(input logic [31:0] hi, input logic [31:0] a, input logic [31:0] b,
                          input bit sgn, input bit poke, input string req);
        logic [31:0] eq, pq;
        bit eov, pov;
        int lat;
        model(hi, a, b, sgn, eq, eov);
        pq = quot_o; pov = ovf_o;
        @(negedge clk);
        start_i = 1'b1; signed_i = sgn; hi_word_i = hi; op_a_i = a; op_b_i = b;
        @(negedge clk);
        start_i = 1'b0; hi_word_i = $urandom; op_a_i = $urandom; op_b_i = $urandom | 32'h1;
        if (b == 32'd0) begin
            chk(dz_trap_o && !busy_o && !done_o, "R3 trap pulse", {dz_trap_o, busy_o, done_o}, 3'b100);
            @(negedge clk);
            chk(!dz_trap_o && !busy_o, "R3 trap one cycle", {dz_trap_o, busy_o}, 2'b00);
            chk(quot_o == pq && ovf_o == pov, "R3 result held", {ovf_o, quot_o}, {pov, pq});
            repeat (70) begin
                @(negedge clk);
                if (done_o) chk(1'b0, "R3 no done", 1, 0);
            end
            return;
        end
        chk(busy_o && !done_o, "R7 busy after start", {busy_o, done_o}, 2'b10);
        lat = 0;
        while (lat < 200) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 10) begin
                start_i = 1'b1; signed_i = ~sgn; op_b_i = 32'd3;
            end else if (poke && lat == 11) begin
                start_i = 1'b0;
            end
            if (done_o) break;
        end
        chk(lat == 64, poke ? "R8 latency with stray start" : "R7 latency", lat, 64);
        chk(!busy_o, "R7 busy low at done", busy_o, 0);
        chk(quot_o == eq, req, quot_o, eq);
        chk(ovf_o == eov, req, ovf_o, eov);
        @(negedge clk);
        chk(!done_o, "R7 done one cycle", done_o, 0);
        repeat (2) @(negedge clk);
        chk(quot_o == eq && ovf_o == eov && !busy_o, "R10 hold", {ovf_o, quot_o}, {eov, eq});
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rh, ra, rb;
        bit rs;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !dz_trap_o && !ovf_o && quot_o == 0, "R9 reset state",
            {busy_o, done_o, dz_trap_o, ovf_o, quot_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(32'd0, 32'd100, 32'd7, 1'b0, 1'b0, "R1 R2 small unsigned");
        run_op(32'd5, 32'h0000_0000, 32'd6, 1'b0, 1'b0, "R1 high word used");
        run_op(32'd1, 32'd0, 32'd1, 1'b0, 1'b0, "R2 unsigned overflow");
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2 unsigned max fit");
        run_op(32'd0, 32'd55, 32'd0, 1'b0, 1'b0, "R3 zero divisor");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0, "R4 neg truncate");
        run_op(32'd0, 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0, "R4 neg divisor");
        run_op(32'd0, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R5 pos saturate");
        run_op(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R4 exact min");
        run_op(32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, "R5 neg saturate");
        run_op(32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6 min by neg");
        run_op(32'h8000_0000, 32'd0, 32'd1, 1'b1, 1'b0, "R6 min by pos");
        run_op(32'h8000_0000, 32'd0, 32'h8000_0000, 1'b1, 1'b0, "R6 min by min");
        run_op(32'd3, 32'd9, 32'd0, 1'b1, 1'b0, "R3 signed zero divisor");
        run_op(32'd0, 32'd1000, 32'd9, 1'b0, 1'b1, "R8 stray start");

        for (int i = 0; i < 250; i++) begin
            rs = $urandom_range(0, 1);
            ra = $urandom;
            rb = $urandom;
            case ($urandom_range(0, 4))
                0: rh = $urandom;
                1: rh = rb >> $urandom_range(1, 31);
                2: rh = {32{ra[31]}};
                3: rh = 32'h8000_0000;
                default: begin rh = $urandom_range(0, 3); rb = $urandom_range(0, 9); end
            endcase
            if (rs) run_op(rh, ra, rb, rs, (i % 17) == 0, "R4 R5 random signed");
            else    run_op(rh, ra, rb, rs, (i % 17) == 0, "R2 random unsigned");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule